// File: doc/BRIEF.md
# Interrupt Status and Mask Register Bank

This block gathers single-cycle event pulses from an I2C master core into sticky status bits. It combines them with a mask and drives one interrupt line plus a second line that covers only the error events. Software sees a small register port with four views that share one bit layout: the status register, the mask register, and two write-only strobe registers.

The status register is cleared by writing ones. Software can read the status word and write the same word back, and only the bits it saw are cleared. The mask cannot be written directly. Writing ones to the enable register unmasks those events, and writing ones to the disable register masks them again. After reset every event is masked, so software enables the events it wants before any interrupt can reach it.

Bit layout, shared by all four views:

| Bit | Event |
|-----|-------|
| 0 | transfer complete |
| 1 | data threshold |
| 2 | NACK |
| 3 | timeout |
| 4 | slave ready |
| 5 | receive overflow |
| 6 | transmit overflow |
| 7 | receive underflow |
| 8 | reserved |
| 9 | arbitration lost |

NACK, receive overflow, transmit overflow, receive underflow and arbitration lost together form the error group.

Top module: `irq_status_bank`

## Requirements
- R1: After reset the status register reads 0x000, the mask register reads 0x2FF (every implemented event masked), and irq and irq_err are 0.
- R2: A one-cycle pulse on evt_pulse[i], for an implemented bit i (0 to 7 or 9), sets status bit i at that clock edge. The bit then stays set on later cycles with no further pulse.
- R3: A write to the status register at offset 0x10 clears each status bit whose wr_data bit is 1. Bits written with 0 keep their value.
- R4: If an event pulse and a status clear for the same bit arrive in the same cycle, that bit is set after the edge.
- R5: A write to offset 0x24 (enable) clears each mask bit whose wr_data bit is 1. A write to offset 0x28 (disable) sets each mask bit whose wr_data bit is 1. Zero bits of either write leave the mask unchanged.
- R6: The mask register at offset 0x20 is read-only. A write to 0x20 leaves both the mask and the status registers unchanged.
- R7: irq is 1 exactly when some bit is set in status AND NOT mask. irq changes at the same clock edge as the register update that causes the change.
- R8: irq_err is 1 exactly when one of bits 2, 5, 6, 7 or 9 is set in status AND NOT mask. An unmasked event outside that group never raises irq_err.
- R9: Reads return zero for the write-only offsets 0x24 and 0x28, for unmapped offsets, for reserved bit 8, and for bits 10 and up. A pulse on evt_pulse[8] has no effect.
- R10: rd_data is registered. It shows the addressed register one cycle after rd_en. The value returned is the register's value before any update made at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Write byte offset |
| wr_data | input | DATA_W (32) | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W (8) | Read byte offset |
| rd_data | output | DATA_W (32) | Registered read data |
| evt_pulse | input | EVT_W (10) | Per-event pulse inputs, one bit per event |
| irq | output | 1 | Registered interrupt, OR of unmasked status |
| irq_err | output | 1 | Registered interrupt for the unmasked error group |

## Verification
The bench aims at cases where a pulse and a write-one-to-clear to the same bit meet in one cycle. A design that gives the clear priority would lose an event there. It writes a read value back to the status register to check that only the seen bits drop, and that a status bit raised by a pulse is not lost. It targets the mask strobes, including writes to the read-only mask offset. A design that decodes 0x20 as writable, or swaps enable and disable, would show a wrong mask and a wrong irq. It also checks the reserved bit 8, the write-only offsets and irq_err for non-error events. A design that leaked reserved bits or treated transfer complete as an error would read nonzero there or raise irq_err.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned EVT_COUNT = 10;

  localparam int unsigned EV_XFER_DONE = 0;
  localparam int unsigned EV_DATA_THR  = 1;
  localparam int unsigned EV_NACK      = 2;
  localparam int unsigned EV_TIMEOUT   = 3;
  localparam int unsigned EV_SLV_RDY   = 4;
  localparam int unsigned EV_RX_OVF    = 5;
  localparam int unsigned EV_TX_OVF    = 6;
  localparam int unsigned EV_RX_UNF    = 7;
  localparam int unsigned EV_RSVD      = 8;
  localparam int unsigned EV_ARB_LOST  = 9;

  function automatic logic [EVT_COUNT-1:0] bit_of(input int unsigned idx);
    logic [EVT_COUNT-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  localparam logic [EVT_COUNT-1:0] IMPL_BITS = ~bit_of(EV_RSVD);
  localparam logic [EVT_COUNT-1:0] ERR_BITS  =
    bit_of(EV_NACK) | bit_of(EV_RX_OVF) | bit_of(EV_TX_OVF) |
    bit_of(EV_RX_UNF) | bit_of(EV_ARB_LOST);
endpackage

// File: rtl/irq_status_regs.sv
module irq_status_regs #(
  parameter int unsigned EVT_W = 10,
  parameter logic [EVT_W-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] set_vec,
  input  logic [EVT_W-1:0] clr_vec,
  output logic [EVT_W-1:0] stat_q,
  output logic [EVT_W-1:0] stat_d
);
  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      // a pulse wins over a clear in the same cycle
      assign stat_d[i] = set_vec[i] | (stat_q[i] & ~clr_vec[i]);
      always_ff @(posedge clk) begin
        if (rst) stat_q[i] <= 1'b0;
        else     stat_q[i] <= stat_d[i];
      end
    end else begin : g_rsvd
      assign stat_d[i] = 1'b0;
      assign stat_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int unsigned EVT_W = 10,
  parameter logic [EVT_W-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] unmask_vec,
  input  logic [EVT_W-1:0] mask_vec,
  output logic [EVT_W-1:0] mask_q,
  output logic [EVT_W-1:0] mask_d
);
  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      assign mask_d[i] = (mask_q[i] | mask_vec[i]) & ~unmask_vec[i];
      always_ff @(posedge clk) begin
        if (rst) mask_q[i] <= 1'b1;
        else     mask_q[i] <= mask_d[i];
      end
    end else begin : g_rsvd
      assign mask_d[i] = 1'b0;
      assign mask_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EVT_W  = 10,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [EVT_W-1:0]  stat_q,
  input  logic [EVT_W-1:0]  mask_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned PAD_W = DATA_W - EVT_W;

  logic [EVT_W-1:0] sel;

  always_comb begin
    if (rd_addr == OFS_STAT)      sel = stat_q;
    else if (rd_addr == OFS_MASK) sel = mask_q;
    else                          sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= {{PAD_W{1'b0}}, sel};
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EVT_W  = EVT_COUNT,
  parameter logic [EVT_W-1:0] IMPL = IMPL_BITS,
  parameter logic [EVT_W-1:0] ERRS = ERR_BITS,
  parameter logic [ADDR_W-1:0] OFS_STAT   = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK   = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_UNMASK = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_DOMASK = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [EVT_W-1:0]  evt_pulse,
  output logic              irq,
  output logic              irq_err
);
  logic [EVT_W-1:0] wbits;
  logic             unused_hi;
  logic [EVT_W-1:0] clr_vec, unmask_vec, mask_vec;
  logic [EVT_W-1:0] status_q, status_d, mask_q, mask_d;
  logic [EVT_W-1:0] live_d;

  assign wbits     = wr_data[EVT_W-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:EVT_W];

  assign clr_vec    = (wr_en && wr_addr == OFS_STAT)   ? wbits : '0;
  assign unmask_vec = (wr_en && wr_addr == OFS_UNMASK) ? wbits : '0;
  assign mask_vec   = (wr_en && wr_addr == OFS_DOMASK) ? wbits : '0;

  irq_status_regs #(.EVT_W(EVT_W), .IMPL(IMPL)) u_stat (
    .clk(clk), .rst(rst), .set_vec(evt_pulse), .clr_vec(clr_vec),
    .stat_q(status_q), .stat_d(status_d)
  );

  irq_mask_regs #(.EVT_W(EVT_W), .IMPL(IMPL)) u_mask (
    .clk(clk), .rst(rst), .unmask_vec(unmask_vec), .mask_vec(mask_vec),
    .mask_q(mask_q), .mask_d(mask_d)
  );

  irq_read_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_W(EVT_W),
    .OFS_STAT(OFS_STAT), .OFS_MASK(OFS_MASK)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .stat_q(status_q), .mask_q(mask_q), .rd_data(rd_data)
  );

  // outputs registered from next-state so they move with the registers
  assign live_d = status_d & ~mask_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      irq     <= |live_d;
      irq_err <= |(live_d & ERRS);
    end
  end
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned EVT_W  = 10,
  parameter logic [EVT_W-1:0] IMPL = '1,
  parameter logic [EVT_W-1:0] ERRS = '0,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h10
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [EVT_W-1:0]  wbits,
  input logic [EVT_W-1:0]  evt_pulse,
  input logic [EVT_W-1:0]  st,
  input logic [EVT_W-1:0]  mk,
  input logic              irq,
  input logic              irq_err
);
  logic [EVT_W-1:0] clr_seen;
  assign clr_seen = (wr_en && wr_addr == OFS_STAT) ? wbits : '0;

  // R1
  mask_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (mk == IMPL));

  // R2
  pulse_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(evt_pulse) & IMPL) & ~st) == '0));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(st) & ~$past(clr_seen)) & ~st) == '0));

  // R7
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(st & ~mk));

  // R8
  irq_err_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_err == |(st & ~mk & ERRS));

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((st | mk) & ~IMPL) == '0);
endmodule

bind irq_status_bank irq_bank_chk #(
  .ADDR_W(ADDR_W), .EVT_W(EVT_W), .IMPL(IMPL), .ERRS(ERRS), .OFS_STAT(OFS_STAT)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wbits(wbits),
  .evt_pulse(evt_pulse), .st(status_q), .mk(mask_q), .irq(irq), .irq_err(irq_err)
);

// File: tb/test_irq_status_bank.sv
`timescale 1ns/1ps
module test_irq_status_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [9:0]  evt_pulse = '0;
  logic        irq, irq_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  localparam logic [7:0] A_ST = 8'h10, A_MK = 8'h20, A_EN = 8'h24, A_DIS = 8'h28;

  always #2.5 clk = ~clk;

  irq_status_bank i_irq_status_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_pulse(evt_pulse), .irq(irq), .irq_err(irq_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse(input logic [9:0] p);
    @(negedge clk);
    evt_pulse = p;
    @(posedge clk); #1;
    evt_pulse = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(A_ST, v); check("R1 status", v, 32'h0);
    rd(A_MK, v); check("R1 mask", v, 32'h2FF);
    check("R1 irq", {30'd0, irq, irq_err}, 32'h0);
  endtask

  task automatic t_masked_event();
    logic [31:0] v;
    do_reset();
    pulse(10'h001);
    check("R7 masked irq low", {31'd0, irq}, 32'h0);
    rd(A_ST, v); check("R2 sticky after pulse", v, 32'h001);
    wr(A_EN, 32'h001);
    check("R7 irq rises on unmask edge", {31'd0, irq}, 32'h1);
    check("R8 no err for bit0", {31'd0, irq_err}, 32'h0);
    rd(A_MK, v); check("R5 enable clears mask bit", v, 32'h2FE);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    do_reset();
    wr(A_EN, 32'h3FF);
    pulse(10'h205);
    rd(A_ST, v); check("R2 multi pulse", v, 32'h205);
    check("R8 err from nack/arb", {31'd0, irq_err}, 32'h1);
    wr(A_ST, 32'h004);
    rd(A_ST, v); check("R3 clear only bit2", v, 32'h201);
    wr(A_ST, v);
    rd(A_ST, v); check("R3 write-back clears all seen", v, 32'h0);
    check("R7 irq low after clear", {30'd0, irq, irq_err}, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    do_reset();
    pulse(10'h008);
    @(negedge clk);
    evt_pulse = 10'h008; wr_en = 1'b1; wr_addr = A_ST; wr_data = 32'h008;
    @(posedge clk); #1;
    evt_pulse = '0; wr_en = 1'b0;
    rd(A_ST, v); check("R4 pulse beats clear", v, 32'h008);
  endtask

  task automatic t_mask_ops();
    logic [31:0] v;
    do_reset();
    wr(A_EN, 32'h0F0);
    rd(A_MK, v); check("R5 enable bits 4-7", v, 32'h20F);
    wr(A_DIS, 32'h030);
    rd(A_MK, v); check("R5 disable bits 4,5", v, 32'h23F);
    wr(A_MK, 32'h000);
    rd(A_MK, v); check("R6 mask write ignored", v, 32'h23F);
    rd(A_ST, v); check("R6 status untouched", v, 32'h0);
    pulse(10'h040);
    check("R8 tx overflow err", {30'd0, irq, irq_err}, 32'h3);
    wr(A_DIS, 32'h040);
    check("R7 irq drops on disable", {30'd0, irq, irq_err}, 32'h0);
  endtask

  task automatic t_zero_reads();
    logic [31:0] v;
    do_reset();
    wr(A_EN, 32'h3FF);
    pulse(10'h100);
    rd(A_ST, v); check("R9 reserved pulse ignored", v, 32'h0);
    check("R9 no irq from reserved", {31'd0, irq}, 32'h0);
    rd(A_MK, v); check("R9 mask bit8 zero", v, 32'h0);
    pulse(10'h0FF);
    rd(A_EN, v);  check("R9 enable reads 0", v, 32'h0);
    rd(A_DIS, v); check("R9 disable reads 0", v, 32'h0);
    rd(8'h14, v); check("R9 unmapped reads 0", v, 32'h0);
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, v); check("R3 all clear", v, 32'h0);
  endtask

  task automatic t_read_timing();
    logic [31:0] v;
    do_reset();
    pulse(10'h002);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = A_ST; wr_en = 1'b1; wr_addr = A_ST; wr_data = 32'h002;
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b0;
    check("R10 read sees pre-clear value", rd_data, 32'h002);
    rd(A_ST, v); check("R10 next read sees clear", v, 32'h0);
  endtask

  initial begin
    t_reset();
    t_masked_event();
    t_w1c();
    t_collision();
    t_mask_ops();
    t_zero_reads();
    t_read_timing();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule